// File: doc/BRIEF.md
# Byte-Lane Write Path for a Flow-Through Synchronous SRAM

This block is the write and read datapath of a flow-through synchronous static RAM. Its 36-bit word is split into four byte lanes. Each lane holds eight data bits and one parity bit. The address, the write data and the write strobes are captured at the rising clock edge.

Writes are steered lane by lane. A global-write strobe selects every lane. Otherwise, a byte-write-enable gate lets the four per-lane strobes choose a subset of lanes. A cycle that selects no lane is a read.

Read data is not registered again. It is looked up combinationally at the captured address and gated by an asynchronous output enable. A one-entry pending-write stage delays the commit of a write into the array. Forwarding from that stage lets a read in the very next cycle return the freshly written lanes before the array holds them. A small parameterised array stands in for the full-size memory.

Top module: `byte_write_sram`

## Requirements
- R1: Address, write data and all write strobes are sampled at the rising edge of `clk_i`. While enabled, `rdata_o` shows the word at the address sampled at the most recent edge, with no further register stage.
- R2: Lane i occupies bits [9i+8:9i] of the word: bits 9i..9i+7 are data and bit 9i+8 is its parity. `bw_ni[i]` selects lane i.
- R3: `bw_ni` takes effect only in a cycle where `bwe_ni` is 0. With `bwe_ni` at 1 and `gw_ni` at 1, the strobes are ignored and the stored word is unchanged.
- R4: A cycle with `gw_ni` at 0 writes all four lanes, whatever `bwe_ni` and `bw_ni` hold.
- R5: A byte write with any one to four strobes at 0 updates exactly those lanes. Every other lane keeps its data and parity bits bit for bit.
- R6: A read at the address written in the immediately preceding cycle returns the new contents in the written lanes and the old contents in the others.
- R7: `oe_ni` acts without the clock. While it is 1, `rdata_o` is all zeros in the default internal-bus variant, or high impedance when `DRIVE_Z` is 1. While it is 0, `rdata_o` carries the read word.
- R8: While `rst_ni` is 0, the captured address and strobes are cleared and every array word is zero, so the first read after reset returns zero.
- R9: A cycle that selects no lane leaves the array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 36 | Write data, four 9-bit lanes |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte-write enable gate, active low |
| bw_ni | input | 4 | Per-lane byte strobes, active low |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | 36 | Read data |

## Verification
Full-word global writes with all strobes held high set the baseline. Comparing them with byte writes that carry identical data shows whether the global strobe really overrides the lane strobes. Byte writes with single lanes, with lanes in pairs, and with alternating lanes, each using parity-heavy data, reveal a misrouted lane boundary or a parity bit that is lost. Cycles that toggle the lane strobes with the enable gate high separate a gated strobe from an ungated one. Write-then-read pairs at the same address are set against pairs at different addresses, which separates forwarding from array contents. Random mixed traffic then covers commit ordering across back-to-back writes.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  localparam int unsigned NUM_LANES = 4;
  localparam int unsigned LANE_BITS = 9;   // 8 data + 1 parity
  localparam int unsigned WORD_BITS = NUM_LANES * LANE_BITS;

  typedef enum logic [1:0] {
    WR_NONE = 2'd0,
    WR_BYTE = 2'd1,
    WR_ALL  = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/sbw_strobe_dec.sv
module sbw_strobe_dec #(
  parameter int unsigned LANES = sbw_pkg::NUM_LANES
) (
  input  logic             gw_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] bw_ni,
  output logic [LANES-1:0] lane_we_o,
  output sbw_pkg::wr_kind_e kind_o
);
  import sbw_pkg::*;

  always_comb begin
    if (!gw_ni) begin
      kind_o    = WR_ALL;
      lane_we_o = '1;
    end else if (!bwe_ni && (bw_ni != '1)) begin
      kind_o    = WR_BYTE;
      lane_we_o = ~bw_ni;
    end else begin
      kind_o    = WR_NONE;
      lane_we_o = '0;
    end
  end
endmodule

// File: rtl/sbw_array.sv
module sbw_array #(
  parameter int unsigned LANES  = sbw_pkg::NUM_LANES,
  parameter int unsigned LANE_W = sbw_pkg::LANE_BITS,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [LANES-1:0]        we_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] cell_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int d = 0; d < DEPTH; d++) cell_q[d] <= '0;
      end else if (we_i[l]) begin
        cell_q[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
      end
    end

    assign rdata_o[l*LANE_W +: LANE_W] = cell_q[raddr_i];
  end
endmodule

// File: rtl/sbw_fwd.sv
module sbw_fwd #(
  parameter int unsigned LANES   = sbw_pkg::NUM_LANES,
  parameter int unsigned LANE_W  = sbw_pkg::LANE_BITS,
  parameter int unsigned ADDR_W  = 4,
  parameter bit          DRIVE_Z = 1'b0
) (
  input  logic [ADDR_W-1:0]       raddr_i,
  input  logic [LANES*LANE_W-1:0] arr_i,
  input  logic [LANES-1:0]        pend_we_i,
  input  logic [ADDR_W-1:0]       pend_addr_i,
  input  logic [LANES*LANE_W-1:0] pend_data_i,
  input  logic                    oe_ni,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  logic                    addr_hit;
  logic [LANES*LANE_W-1:0] merged;

  assign addr_hit = (pend_addr_i == raddr_i);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged[l*LANE_W +: LANE_W] = (addr_hit && pend_we_i[l])
                                        ? pend_data_i[l*LANE_W +: LANE_W]
                                        : arr_i[l*LANE_W +: LANE_W];
  end

  if (DRIVE_Z) begin : g_tri
    assign rdata_o = oe_ni ? 'z : merged;
  end else begin : g_bus
    assign rdata_o = oe_ni ? '0 : merged;
  end
endmodule

// File: rtl/byte_write_sram.sv
module byte_write_sram #(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned LANES   = sbw_pkg::NUM_LANES,
  parameter int unsigned LANE_W  = sbw_pkg::LANE_BITS,
  parameter bit          DRIVE_Z = 1'b0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    gw_ni,
  input  logic                    bwe_ni,
  input  logic [LANES-1:0]        bw_ni,
  input  logic                    oe_ni,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int unsigned WORD_W = LANES * LANE_W;

  logic [LANES-1:0]  lane_we;
  sbw_pkg::wr_kind_e wr_kind;

  // input capture stage
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic [LANES-1:0]  wmask_q;
  // pending write, committed one edge later
  logic [ADDR_W-1:0] pend_addr_q;
  logic [WORD_W-1:0] pend_data_q;
  logic [LANES-1:0]  pend_mask_q;

  logic [WORD_W-1:0] arr_rdata;

  sbw_strobe_dec #(.LANES(LANES)) u_dec (
    .gw_ni     (gw_ni),
    .bwe_ni    (bwe_ni),
    .bw_ni     (bw_ni),
    .lane_we_o (lane_we),
    .kind_o    (wr_kind)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q      <= '0;
      wdata_q     <= '0;
      wmask_q     <= '0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
      pend_mask_q <= '0;
    end else begin
      addr_q      <= addr_i;
      wdata_q     <= wdata_i;
      wmask_q     <= (wr_kind == sbw_pkg::WR_NONE) ? '0 : lane_we;
      pend_addr_q <= addr_q;
      pend_data_q <= wdata_q;
      pend_mask_q <= wmask_q;
    end
  end

  sbw_array #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (pend_mask_q),
    .waddr_i (pend_addr_q),
    .wdata_i (pend_data_q),
    .raddr_i (addr_q),
    .rdata_o (arr_rdata)
  );

  sbw_fwd #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W), .DRIVE_Z(DRIVE_Z)) u_fwd (
    .raddr_i     (addr_q),
    .arr_i       (arr_rdata),
    .pend_we_i   (pend_mask_q),
    .pend_addr_i (pend_addr_q),
    .pend_data_i (pend_data_q),
    .oe_ni       (oe_ni),
    .rdata_o     (rdata_o)
  );
endmodule

// File: rtl/sbw_chk.sv
module sbw_chk #(
  parameter int unsigned LANES   = 4,
  parameter int unsigned WORD_W  = 36,
  parameter bit          DRIVE_Z = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              gw_ni,
  input logic              bwe_ni,
  input logic [LANES-1:0]  bw_ni,
  input logic              oe_ni,
  input logic [WORD_W-1:0] rdata_o,
  input logic [LANES-1:0]  mask_q,
  input logic [LANES-1:0]  pend_mask
);
  // R4
  gw_all_lanes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gw_ni |=> mask_q == '1);

  // R3
  bw_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gw_ni && bwe_ni) |=> mask_q == '0);

  // R5
  bw_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gw_ni && !bwe_ni) |=> mask_q == ~$past(bw_ni));

  // R6
  pend_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q != '0) |=> pend_mask == $past(mask_q));

  if (!DRIVE_Z) begin : g_bus
    // R7
    oe_off_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oe_ni |-> rdata_o == '0);
  end
endmodule

bind byte_write_sram sbw_chk #(.LANES(LANES), .WORD_W(LANES*LANE_W), .DRIVE_Z(DRIVE_Z)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .gw_ni     (gw_ni),
  .bwe_ni    (bwe_ni),
  .bw_ni     (bw_ni),
  .oe_ni     (oe_ni),
  .rdata_o   (rdata_o),
  .mask_q    (wmask_q),
  .pend_mask (pend_mask_q)
);

// File: tb/byte_write_sram_test.sv
module byte_write_sram_test;
  localparam int CLK_P = 10;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [35:0]   wdata_i = '0;
  logic          gw_ni = 1'b1;
  logic          bwe_ni = 1'b1;
  logic [3:0]    bw_ni = 4'hf;
  logic          oe_ni = 1'b0;
  logic [35:0]   rdata_o;

  logic [35:0] model [DEPTH];
  int vec = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  byte_write_sram #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .gw_ni(gw_ni), .bwe_ni(bwe_ni), .bw_ni(bw_ni), .oe_ni(oe_ni), .rdata_o(rdata_o)
  );

  task automatic check(input logic [35:0] exp, input string req);
    vec++;
    if (rdata_o !== exp) begin
      bad++;
      $display("FAIL %s: rdata_o=%h expected %h", req, rdata_o, exp);
    end
  endtask

  // one bus cycle: drive at falling edge, check after the next rising edge
  task automatic cyc(input logic [AW-1:0] a, input logic [35:0] d, input logic gw,
                     input logic bwe, input logic [3:0] bw, input string req);
    logic [35:0] exp;
    logic [3:0]  sel;
    @(negedge clk);
    addr_i = a; wdata_i = d; gw_ni = gw; bwe_ni = bwe; bw_ni = bw;
    exp = oe_ni ? 36'h0 : model[a];
    sel = !gw ? 4'hf : (!bwe ? ~bw : 4'h0);
    for (int l = 0; l < 4; l++)
      if (sel[l]) model[a][l*9 +: 9] = d[l*9 +: 9];
    @(posedge clk);
    #(CLK_P/4);
    check(exp, req);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req);
    cyc(a, 36'h0, 1'b1, 1'b1, 4'hf, req);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    check(36'h0, "R8 reset");
    @(negedge clk);
    rst_ni = 1'b1;
    rd(4'd5, "R8 first read");
    // R4: global write over all lanes, strobes high
    for (int i = 0; i < DEPTH; i++)
      cyc(i[AW-1:0], {4{i[8:0] ^ 9'h1a5}}, 1'b0, 1'b1, 4'hf, "R4 global fill");
    for (int i = 0; i < DEPTH; i++) rd(i[AW-1:0], "R1 readback");
    // R4: global overrides enable gate and strobes
    cyc(4'd3, 36'hf_0f0f_0f0f, 1'b0, 1'b0, 4'h5, "R4 override");
    rd(4'd3, "R4 readback");
    // R3: strobes ignored while bwe_ni high
    cyc(4'd3, 36'h1_2345_6789, 1'b1, 1'b1, 4'h0, "R3 gated");
    rd(4'd3, "R3 unchanged");
    // R2/R5: each single lane, parity-heavy data
    for (int l = 0; l < 4; l++) begin
      cyc(4'd7, 36'hf_ffff_ffff, 1'b1, 1'b0, ~(4'b1 << l), "R2 single lane");
      rd(4'd7, "R5 single lane readback");
    end
    cyc(4'd8, 36'h8_0402_0100, 1'b1, 1'b0, 4'b1010, "R5 lanes 0,2");
    rd(4'd8, "R5 alt lanes");
    cyc(4'd9, 36'h0_0000_0000, 1'b1, 1'b0, 4'b0011, "R5 lanes 2,3");
    rd(4'd9, "R5 pair lanes");
    cyc(4'd10, 36'ha_aaaa_aaaa, 1'b1, 1'b0, 4'b0000, "R5 all four");
    rd(4'd10, "R5 all four readback");
    // R9: read cycle with bwe low but every strobe high
    cyc(4'd10, 36'h5_5555_5555, 1'b1, 1'b0, 4'hf, "R9 no lane");
    rd(4'd10, "R9 unchanged");
    // R6: write then immediate read, same vs different address
    cyc(4'd11, 36'h3_c3c3_c3c3, 1'b1, 1'b0, 4'b0110, "R6 write");
    rd(4'd11, "R6 pass-through");
    cyc(4'd12, 36'h9_9999_9999, 1'b0, 1'b1, 4'hf, "R6 write");
    rd(4'd13, "R6 other address");
    rd(4'd12, "R6 later read");
    cyc(4'd1, 36'h1_1111_1111, 1'b0, 1'b1, 4'hf, "R6 back-to-back a");
    cyc(4'd1, 36'h2_2222_2222, 1'b1, 1'b0, 4'b1100, "R6 back-to-back b");
    rd(4'd1, "R6 chained pass-through");
    // R7: asynchronous output enable
    @(negedge clk);
    oe_ni = 1'b1; #1;
    check(36'h0, "R7 oe off");
    oe_ni = 1'b0; #1;
    check(model[1], "R7 oe on");
    oe_ni = 1'b1;
    rd(4'd2, "R7 disabled read");
    oe_ni = 1'b0;
    // mixed random traffic
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      logic [35:0]   d;
      logic [2:0]    k;
      a = $urandom_range(0, DEPTH-1);
      d = {$urandom, $urandom};
      k = $urandom_range(0, 7);
      if (k < 2)      cyc(a, d, 1'b0, $urandom_range(0, 1), 4'($urandom), "R4 random");
      else if (k < 5) cyc(a, d, 1'b1, 1'b0, 4'($urandom), "R5 random");
      else if (k < 6) cyc(a, d, 1'b1, 1'b1, 4'($urandom), "R3 random");
      else            rd(a, "R6 random");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule